// File: doc/BRIEF.md
# Power-On Strap Sampling Sequencer

This block decides, once per power-up, how a group of five dual-purpose pads will behave. When the supply-detect input goes true, the pads stay undriven for a fixed window so that external pull resistors can settle each pad to a known level. When the window ends, the block samples those levels through a small synchronizer and stores them. On the next cycle it turns the pads into driven clock outputs. The stored bits stay fixed until power is lost.

Four of the stored bits form the frequency select code. The fifth decides what the shared pad does: it either carries the reference clock out or acts as the PCI clock-stop input. A software select input can replace the strapped code with a software code. The effective code is decoded into the PCI clock divisor, which is 2, 3 or 4. The PLL and the pad cells lie outside this block.

Top module: `pad_strap_sequencer`

## Requirements
- R1: From the cycle in which `pwr_good_i` goes high until the window ends, `pad_oe_o`, `done_o`, `share_ref_oe_o` and `stop_sel_o` all stay 0.
- R2: Let `pwr_good_i` go high before clock edge 1. Then the strap levels are captured at edge `WIN_CYCLES` (counted with `pwr_good_i` high). `done_o` is 1 for exactly the single cycle after that edge.
- R3: `pad_oe_o` rises in the cycle after `done_o` and stays high for as long as `pwr_good_i` stays high.
- R4: `pin_lvl_i[3:0]` is the frequency code, bit 3 first. `pin_lvl_i[4]` is the mode bit. These values must be stable for `SYNC_STAGES` cycles before the capture edge, and `strap_code_o` and `strap_mode_o` then show them. Any pin change after the capture has no effect on those outputs.
- R5: `done_o` never rises a second time while `pwr_good_i` stays high.
- R6: A clock edge with `pwr_good_i` low clears the stored straps, `done_o` and `pad_oe_o`. When `pwr_good_i` returns high, a full new window starts, even if the earlier window was cut short.
- R7: After the pads are enabled, mode bit 0 sets `stop_sel_o`=1 and `share_ref_oe_o`=0. Mode bit 1 sets `share_ref_oe_o`=1 and `stop_sel_o`=0. The two outputs are never 1 together.
- R8: `pci_div_o` is 4 for effective codes 12 to 15, 2 for codes 1 to 3, and 3 for code 0 and codes 4 to 11.
- R9: When `sw_sel_i`=1, the effective code `eff_code_o` equals `sw_code_i`. When `sw_sel_i`=0, it equals the stored strap code. The switch takes effect combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| pwr_good_i | input | 1 | Supply detect; synchronous active-low reset of the whole block |
| pin_lvl_i | input | 5 | Sensed pad levels: [3:0] frequency code, [4] mode |
| sw_sel_i | input | 1 | Software code replaces strapped code |
| sw_code_i | input | 4 | Software frequency code |
| pad_oe_o | output | 1 | Output-driver enable for the dual-purpose pads |
| done_o | output | 1 | One-cycle pulse when the stored straps first become valid |
| strap_code_o | output | 4 | Stored frequency code |
| strap_mode_o | output | 1 | Stored mode bit |
| share_ref_oe_o | output | 1 | Shared pad drives the reference clock |
| stop_sel_o | output | 1 | Shared pad acts as the PCI clock-stop input |
| eff_code_o | output | 4 | Effective frequency code after the software override |
| pci_div_o | output | 3 | PCI divisor value (2, 3 or 4) |

## Verification
The bench builds the block with `WIN_CYCLES`=24 and `SYNC_STAGES`=2. The short window makes the exact capture cycle cheap to reach, so the bench can test it several times over. It covers a power loss in the middle of a window, which must restart the count, and two full power cycles with different strap patterns. The bench also steps the software override through all sixteen codes. This exercises every decode region and each of its boundaries.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int FS_W  = 4;
    localparam int NPIN  = FS_W + 1;

    typedef struct packed {
        logic            mode;
        logic [FS_W-1:0] code;
    } strap_t;

    // Divisor value for the PCI clock from a frequency code.
    function automatic logic [2:0] div_of(input logic [FS_W-1:0] c);
        if (c[3:2] == 2'b11)                 return 3'd4;
        else if (c != '0 && c[3:2] == 2'b00) return 3'd2;
        else                                  return 3'd3;
    endfunction
endpackage

// File: rtl/pss_window_timer.sv
// Window timer: counts WIN_CYCLES reference edges after supply detect,
// gives a one-shot capture strobe, a registered done pulse and a sticky
// output enable. Assumes pwr_good_i is already synchronous to clk_i.
module pss_window_timer #(
    parameter int WIN_CYCLES = 28636
) (
    input  logic clk_i,
    input  logic pwr_good_i,
    output logic capture_o,
    output logic done_o,
    output logic oe_o
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             fired_q;
    logic             done_q;
    logic             oe_q;
    logic             last_w;

    assign last_w    = (cnt_q == CNT_W'(WIN_CYCLES - 1));
    assign capture_o = !fired_q && last_w;

    // Count the window once; freeze after the capture edge.
    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!fired_q) begin
            if (last_w) fired_q <= 1'b1;
            else        cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Done pulse follows capture; enable follows done and sticks.
    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            done_q <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            done_q <= capture_o;
            oe_q   <= oe_q | done_q;
        end
    end

    assign done_o = done_q;
    assign oe_o   = oe_q;

    p_no_oe_unfired_r1: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !fired_q |-> !oe_q && !done_q);
    p_done_once_r5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        done_q |=> !done_q);
    p_oe_after_done_r3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        $rose(oe_q) |-> $past(done_q));
    p_oe_hold_r3: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        oe_q |=> oe_q);
    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        cnt_q <= CNT_W'(WIN_CYCLES - 1));
endmodule

// File: rtl/pss_strap_capture.sv
// Strap capture: passes the sensed pad levels through a synchronizer of
// SYNC_STAGES flops and stores them on the capture strobe. Only a cycle
// with pwr_good_i low clears the stored value.
module pss_strap_capture
    import pss_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            pwr_good_i,
    input  logic [NPIN-1:0] pin_lvl_i,
    input  logic            capture_i,
    output strap_t          strap_o
);
    logic [NPIN-1:0] sync_q [SYNC_STAGES];
    strap_t          strap_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        // One synchronizer stage.
        always_ff @(posedge clk_i) begin
            if (!pwr_good_i) sync_q[g] <= '0;
            else if (g == 0) sync_q[g] <= pin_lvl_i;
            else             sync_q[g] <= sync_q[(g == 0) ? 0 : g - 1];
        end
    end

    // Store the synchronized levels exactly at the capture strobe.
    always_ff @(posedge clk_i) begin
        if (!pwr_good_i)    strap_q <= '0;
        else if (capture_i) strap_q <= strap_t'(sync_q[SYNC_STAGES-1]);
    end

    assign strap_o = strap_q;

    p_hold_r4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !capture_i |=> $stable(strap_q));
    p_capture_r4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        capture_i |=> strap_q == $past(sync_q[SYNC_STAGES-1]));
endmodule

// File: rtl/pss_div_decode.sv
// Divider decode: applies the software override to the strapped code and
// maps the effective code to a PCI divisor. Purely combinational.
module pss_div_decode
    import pss_pkg::*;
(
    input  logic            clk_i,
    input  logic            pwr_good_i,
    input  logic            sw_sel_i,
    input  logic [FS_W-1:0] sw_code_i,
    input  logic [FS_W-1:0] strap_code_i,
    output logic [FS_W-1:0] eff_code_o,
    output logic [2:0]      div_o
);
    // Pick the code source, then decode the divisor.
    always_comb begin
        eff_code_o = sw_sel_i ? sw_code_i : strap_code_i;
        div_o      = div_of(eff_code_o);
    end

    p_div_legal_r8: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        div_o inside {3'd2, 3'd3, 3'd4});
    p_div4_r8: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (eff_code_o[3:2] == 2'b11) |-> div_o == 3'd4);
    p_sw_r9: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !sw_sel_i |-> eff_code_o == strap_code_i);
endmodule

// File: rtl/pad_strap_sequencer.sv
// Top: power-on strap sequencer. Holds pads undriven for WIN_CYCLES after
// supply detect, stores the strap levels, then enables the pads and
// selects the function of the shared pad. Assumes pwr_good_i is
// synchronous to clk_i and that the pads are stable during the window.
module pad_strap_sequencer
    import pss_pkg::*;
#(
    parameter int WIN_CYCLES  = 28636,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk_i,
    input  logic        pwr_good_i,
    input  logic [4:0]  pin_lvl_i,
    input  logic        sw_sel_i,
    input  logic [3:0]  sw_code_i,
    output logic        pad_oe_o,
    output logic        done_o,
    output logic [3:0]  strap_code_o,
    output logic        strap_mode_o,
    output logic        share_ref_oe_o,
    output logic        stop_sel_o,
    output logic [3:0]  eff_code_o,
    output logic [2:0]  pci_div_o
);
    logic   capture_w;
    logic   oe_w;
    strap_t strap_w;

    pss_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
        .clk_i     (clk_i),
        .pwr_good_i(pwr_good_i),
        .capture_o (capture_w),
        .done_o    (done_o),
        .oe_o      (oe_w)
    );

    pss_strap_capture #(.SYNC_STAGES(SYNC_STAGES)) u_capture (
        .clk_i     (clk_i),
        .pwr_good_i(pwr_good_i),
        .pin_lvl_i (pin_lvl_i),
        .capture_i (capture_w),
        .strap_o   (strap_w)
    );

    pss_div_decode u_decode (
        .clk_i       (clk_i),
        .pwr_good_i  (pwr_good_i),
        .sw_sel_i    (sw_sel_i),
        .sw_code_i   (sw_code_i),
        .strap_code_i(strap_w.code),
        .eff_code_o  (eff_code_o),
        .div_o       (pci_div_o)
    );

    // Shared pad function, valid only once the pads are enabled.
    always_comb begin
        pad_oe_o       = oe_w;
        strap_code_o   = strap_w.code;
        strap_mode_o   = strap_w.mode;
        share_ref_oe_o = oe_w &  strap_w.mode;
        stop_sel_o     = oe_w & ~strap_w.mode;
    end

    p_shared_excl_r7: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !(share_ref_oe_o && stop_sel_o));
    p_quiet_window_r1: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !pad_oe_o |-> !share_ref_oe_o && !stop_sel_o);
endmodule

// File: tb/pad_strap_sequencer_tb_top.sv
module pad_strap_sequencer_tb_top;
    localparam int WIN = 24;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic [4:0] pin_lvl = '0;
    logic       sw_sel = 1'b0;
    logic [3:0] sw_code = '0;
    logic       pad_oe, done, strap_mode, share_ref, stop_sel;
    logic [3:0] strap_code, eff_code;
    logic [2:0] pci_div;

    always #2 clk = ~clk;

    pad_strap_sequencer #(.WIN_CYCLES(WIN), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .pwr_good_i(pwr_good), .pin_lvl_i(pin_lvl),
        .sw_sel_i(sw_sel), .sw_code_i(sw_code), .pad_oe_o(pad_oe),
        .done_o(done), .strap_code_o(strap_code), .strap_mode_o(strap_mode),
        .share_ref_oe_o(share_ref), .stop_sel_o(stop_sel),
        .eff_code_o(eff_code), .pci_div_o(pci_div)
    );

    typedef enum int {S_OE, S_DONE, S_CODE, S_MODE, S_REF, S_STOP, S_DIV, S_EFF} sig_e;
    typedef struct {
        int    cyc;
        sig_e  sig;
        int    expv;
        string req;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   errors = 0;
    int   checks = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sig_val(sig_e s);
        case (s)
            S_OE:   return int'(pad_oe);
            S_DONE: return int'(done);
            S_CODE: return int'(strap_code);
            S_MODE: return int'(strap_mode);
            S_REF:  return int'(share_ref);
            S_STOP: return int'(stop_sel);
            S_DIV:  return int'(pci_div);
            default: return int'(eff_code);
        endcase
    endfunction

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        exp_t it;
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            it = q.pop_front();
            checks++;
            if (it.cyc < cyc) begin
                errors++;
                $display("FAIL %s: check for cycle %0d missed (now %0d, expected %0d)",
                         it.req, it.cyc, cyc, it.expv);
            end else if (sig_val(it.sig) != it.expv) begin
                errors++;
                $display("FAIL %s: %s at cycle %0d actual=%0d expected=%0d",
                         it.req, it.sig.name(), cyc, sig_val(it.sig), it.expv);
            end
        end
    end

    task automatic push(int c, sig_e s, int v, string r);
        exp_t it;
        it.cyc = c; it.sig = s; it.expv = v; it.req = r;
        q.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(int t);
        while (cyc < t) step(1);
    endtask

    function automatic int ref_div(int c);
        if (c >= 12) return 4;
        if (c >= 1 && c <= 3) return 2;
        return 3;
    endfunction

    // Raise supply with the given straps and queue the window expectations.
    task automatic power_up(logic [4:0] pins);
        int k;
        pin_lvl  = pins;
        pwr_good = 1'b1;
        k = cyc;
        push(k + 1,       S_OE,   0, "R1");
        push(k + WIN - 1, S_DONE, 0, "R2");
        push(k + WIN - 1, S_OE,   0, "R1");
        push(k + WIN,     S_DONE, 1, "R2");
        push(k + WIN,     S_OE,   0, "R3");
        push(k + WIN,     S_REF,  0, "R1");
        push(k + WIN,     S_STOP, 0, "R1");
        push(k + WIN,     S_CODE, int'(pins[3:0]), "R4");
        push(k + WIN,     S_MODE, int'(pins[4]), "R4");
        push(k + WIN + 1, S_DONE, 0, "R2");
        push(k + WIN + 1, S_OE,   1, "R3");
        push(k + WIN + 1, S_REF,  int'(pins[4]), "R7");
        push(k + WIN + 1, S_STOP, int'(!pins[4]), "R7");
        push(k + WIN + 1, S_DIV,  ref_div(int'(pins[3:0])), "R8");
        push(k + WIN + 1, S_EFF,  int'(pins[3:0]), "R9");
        wait_cyc(k + WIN + 2);
    endtask

    task automatic power_down();
        int c;
        pwr_good = 1'b0;
        c = cyc;
        push(c + 1, S_OE,   0, "R6");
        push(c + 1, S_DONE, 0, "R6");
        push(c + 1, S_CODE, 0, "R6");
        push(c + 1, S_MODE, 0, "R6");
        step(3);
    endtask

    initial begin
        int base;
        step(4);
        push(cyc, S_OE, 0, "R6");
        push(cyc, S_DONE, 0, "R6");
        push(cyc, S_CODE, 0, "R6");
        step(1);

        // First power-up: mode 0, code 11.
        power_up(5'b0_1011);

        // Pins change after capture: stored values and pulse unaffected.
        pin_lvl = 5'b1_0100;
        base = cyc;
        for (int i = 1; i <= 10; i++) push(base + i, S_DONE, 0, "R5");
        push(base + 10, S_CODE, 11, "R4");
        push(base + 10, S_MODE, 0, "R4");
        push(base + 10, S_OE, 1, "R3");
        wait_cyc(base + 11);

        // Software override across every code.
        sw_sel = 1'b1;
        for (int c = 0; c < 16; c++) begin
            sw_code = 4'(c);
            push(cyc, S_EFF, c, "R9");
            push(cyc, S_DIV, ref_div(c), "R8");
            step(1);
        end
        sw_sel = 1'b0;
        push(cyc, S_EFF, 11, "R9");
        step(1);

        power_down();

        // Window cut short by a supply drop, then a full restart.
        pin_lvl  = 5'b1_1101;
        pwr_good = 1'b1;
        step(10);
        power_down();
        power_up(5'b1_1101);

        power_down();
        power_up(5'b0_0010);

        step(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule